// File: doc/BRIEF.md
# Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It is meant for the decode stage, once the instruction is known to be a branch. It keeps several banks of 2-bit saturating counters. Low-order bits of the branch address, above the two alignment bits, index each bank. A short global record of recent branch outcomes chooses which bank answers. Branches whose outcome depends on the path that led to them therefore train separate counters.

The lookup side is combinational. It takes the branch address, the decoded sign-extended offset and the next address that fetch assumed. It returns the counter, the direction, the next address implied by that direction, and a redirect flag for when this next address differs from the fetch guess. The training side takes a resolved branch address and its outcome. It moves the selected counter one step and shifts the outcome into the history. Training takes effect at the next clock edge, so a lookup in the same cycle sees the old state.

Top module: `branch_dir_predictor`

## Requirements
- R1: Reset (rst_n low at a clock edge) sets every counter to weakly not-taken (2'b01) and clears the history to zero.
- R2: The predicted direction lk_taken equals bit 1 of the selected counter lk_ctr.
- R3: An update with up_taken=1 increments the selected counter and stops at 2'b11. An update with up_taken=0 decrements it and stops at 2'b00.
- R4: From a strong state (2'b11 or 2'b00), a single contrary outcome leaves the predicted direction unchanged. A second contrary outcome in a row flips it.
- R5: The entry index is pc[IDX_BITS+1:2]. Address bits 1:0 and bits above IDX_BITS+1 do not select the entry, so such aliases share a counter.
- R6: On each update the history shifts left by one and up_taken enters bit 0. Without up_valid the history holds, and lookups never change it.
- R7: The current history value selects the bank, for both lookup and update. The same address under different history values reaches independent counters.
- R8: lk_next_pc is lk_pc + lk_offset when lk_taken is 1, and lk_pc + 4 otherwise.
- R9: lk_redirect is 1 exactly when lk_valid is 1 and lk_next_pc differs from lk_ppc.
- R10: When a lookup and an update hit the same entry in one cycle, the lookup returns the counter value from before the update.
- R11: With up_valid low, no counter changes, whatever up_pc and up_taken carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | A decoded branch is being looked up |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_offset | input | PC_W | Sign-extended branch offset from decode |
| lk_ppc | input | PC_W | Next address that fetch assumed |
| lk_ctr | output | 2 | Selected counter value |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_next_pc | output | PC_W | Next address implied by the prediction |
| lk_redirect | output | 1 | Fetch must be redirected to lk_next_pc |
| lk_hist | output | HIST_BITS | Current global history |
| up_valid | input | 1 | A resolved branch trains the predictor |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A wrong counter shows on lk_ctr and lk_taken in the same cycle that its entry is looked up under the matching history. It can stay hidden, though, until that address and history come back together, so the stimulus revisits one address under every history value. A wrong history shows on lk_hist in the cycle after the update that caused it. It also moves later updates and lookups into the wrong bank, so a later counter readback fails too. Same-cycle lookup and update on one entry are checked on both sides of the edge.

// File: rtl/bdp_pkg.sv
// Shared types and the counter step rule for the two-level direction predictor.
// Assumes 2-bit counters; the MSB of a counter is the taken prediction.
package bdp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_NT = 2'b01;
    localparam ctr_t CTR_MAX     = 2'b11;
    localparam ctr_t CTR_MIN     = 2'b00;

    // Move a counter one step toward the resolved outcome, saturating at the ends.
    function automatic ctr_t ctr_step(ctr_t cur, logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'b01;
        end else begin
            nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'b01;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bdp_history.sv
// Global outcome history: a shift register fed by resolved branches.
// Assumes at most one resolved branch per cycle; the newest outcome lands in bit 0.
module bdp_history #(
    parameter int HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 outcome,
    output logic [HIST_BITS-1:0] hist
);

    logic [HIST_BITS-1:0] hist_q;

    // Clear on reset; shift the new outcome in on each update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            if (HIST_BITS == 1) begin
                hist_q <= outcome;
            end else begin
                hist_q <= {hist_q[HIST_BITS-2:0], outcome};
            end
        end
    end

    assign hist = hist_q;

endmodule

// File: rtl/bdp_bank.sv
// One bank of 2-bit saturating counters with a combinational read port and
// one trained write port. Assumes the caller gates wr_en by bank selection.
// The read returns the stored value, so a same-cycle write is not visible.
module bdp_bank
    import bdp_pkg::*;
#(
    parameter int IDX_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_idx,
    output ctr_t                rd_ctr,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic                wr_taken
);

    localparam int ENTRIES = 1 << IDX_BITS;

    ctr_t tbl [ENTRIES];

    // Reset every counter to weakly not-taken; otherwise train the addressed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl[i] <= CTR_WEAK_NT;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
        end
    end

    // Combinational read of the addressed counter.
    always_comb begin
        rd_ctr = tbl[rd_idx];
    end

endmodule

// File: rtl/bdp_target.sv
// Next-address former: picks the branch target or the fall-through address
// from the predicted direction and flags disagreement with fetch's guess.
// Assumes the offset arrives already sign-extended to PC_W bits.
module bdp_target #(
    parameter int PC_W     = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            valid,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] offset,
    input  logic [PC_W-1:0] ppc,
    input  logic            taken,
    output logic [PC_W-1:0] next_pc,
    output logic            redirect
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    // Choose the next address and compare it with the fetch-time guess.
    always_comb begin
        next_pc  = taken ? (pc + offset) : (pc + STEP);
        redirect = valid && (next_pc != ppc);
    end

endmodule

// File: rtl/branch_dir_predictor.sv
// Two-level branch direction predictor top. The global history picks one of
// 2**HIST_BITS counter banks; PC bits above the alignment bits pick the entry.
// Lookup is combinational; training lands at the next clock edge.
// Assumes one lookup and one update per cycle at most.
module branch_dir_predictor
    import bdp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int IDX_BITS  = 10,
    parameter int HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [PC_W-1:0]      lk_pc,
    input  logic [PC_W-1:0]      lk_offset,
    input  logic [PC_W-1:0]      lk_ppc,
    output logic [1:0]           lk_ctr,
    output logic                 lk_taken,
    output logic [PC_W-1:0]      lk_next_pc,
    output logic                 lk_redirect,
    output logic [HIST_BITS-1:0] lk_hist,
    input  logic                 up_valid,
    input  logic [PC_W-1:0]      up_pc,
    input  logic                 up_taken
);

    localparam int NBANK   = 1 << HIST_BITS;
    localparam int ALIGN   = 2;
    localparam int IDX_TOP = IDX_BITS + ALIGN - 1;

    logic [HIST_BITS-1:0] hist;
    logic [IDX_BITS-1:0]  rd_idx;
    logic [IDX_BITS-1:0]  wr_idx;
    ctr_t                 bank_rd [NBANK];
    ctr_t                 sel_ctr;

    assign rd_idx = lk_pc[IDX_TOP:ALIGN];
    assign wr_idx = up_pc[IDX_TOP:ALIGN];

    bdp_history #(
        .HIST_BITS(HIST_BITS)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(up_valid),
        .outcome (up_taken),
        .hist    (hist)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bank_we;
        assign bank_we = up_valid && (hist == HIST_BITS'(b));

        bdp_bank #(
            .IDX_BITS(IDX_BITS)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (rd_idx),
            .rd_ctr  (bank_rd[b]),
            .wr_en   (bank_we),
            .wr_idx  (wr_idx),
            .wr_taken(up_taken)
        );
    end

    // Select the counter of the bank named by the current history.
    always_comb begin
        sel_ctr = bank_rd[hist];
    end

    assign lk_ctr   = sel_ctr;
    assign lk_taken = sel_ctr[1];
    assign lk_hist  = hist;

    bdp_target #(
        .PC_W(PC_W)
    ) u_target (
        .valid   (lk_valid),
        .pc      (lk_pc),
        .offset  (lk_offset),
        .ppc     (lk_ppc),
        .taken   (lk_taken),
        .next_pc (lk_next_pc),
        .redirect(lk_redirect)
    );

endmodule

// File: rtl/bdp_checker.sv
// Property checker for the direction predictor, bound to the top module.
// Observes ports only.
module bdp_checker #(
    parameter int PC_W      = 32,
    parameter int HIST_BITS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_valid,
    input logic [PC_W-1:0]      lk_pc,
    input logic [PC_W-1:0]      lk_offset,
    input logic [PC_W-1:0]      lk_ppc,
    input logic [1:0]           lk_ctr,
    input logic                 lk_taken,
    input logic [PC_W-1:0]      lk_next_pc,
    input logic                 lk_redirect,
    input logic [HIST_BITS-1:0] lk_hist,
    input logic                 up_valid,
    input logic                 up_taken
);

    // R1
    hist_reset_chk: assert property (@(posedge clk)
        !rst_n |=> lk_hist == '0);

    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> lk_hist == HIST_BITS'({$past(lk_hist), $past(up_taken)}));

    // R6
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(lk_hist));

    // R2
    taken_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken == lk_ctr[1]);

    // R8
    next_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_next_pc == (lk_taken ? lk_pc + lk_offset : lk_pc + PC_W'(4)));

    // R9
    redirect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_redirect);

endmodule

bind branch_dir_predictor bdp_checker #(
    .PC_W     (PC_W),
    .HIST_BITS(HIST_BITS)
) u_bdp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_pc      (lk_pc),
    .lk_offset  (lk_offset),
    .lk_ppc     (lk_ppc),
    .lk_ctr     (lk_ctr),
    .lk_taken   (lk_taken),
    .lk_next_pc (lk_next_pc),
    .lk_redirect(lk_redirect),
    .lk_hist    (lk_hist),
    .up_valid   (up_valid),
    .up_taken   (up_taken)
);

// File: tb/test_branch_dir_predictor.sv
module test_branch_dir_predictor;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            lk_valid;
    logic [PC_W-1:0] lk_pc;
    logic [PC_W-1:0] lk_offset;
    logic [PC_W-1:0] lk_ppc;
    logic [1:0]      lk_ctr;
    logic            lk_taken;
    logic [PC_W-1:0] lk_next_pc;
    logic            lk_redirect;
    logic [1:0]      lk_hist;
    logic            up_valid;
    logic [PC_W-1:0] up_pc;
    logic            up_taken;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    branch_dir_predictor #(.PC_W(PC_W), .IDX_BITS(10), .HIST_BITS(2)) i_branch_dir_predictor (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_offset(lk_offset), .lk_ppc(lk_ppc),
        .lk_ctr(lk_ctr), .lk_taken(lk_taken), .lk_next_pc(lk_next_pc),
        .lk_redirect(lk_redirect), .lk_hist(lk_hist),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    // Per step: address, outcome to train, expected history and counter before training.
    typedef struct packed {
        logic [31:0] pc;
        logic        taken;
        logic [1:0]  hist;
        logic [1:0]  ctr;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0100, 1'b1, 2'd0, 2'b01},  // R3 bank0 weak NT -> 10
        '{32'h0000_0100, 1'b1, 2'd1, 2'b01},  // R7 bank1 untouched
        '{32'h0000_0100, 1'b1, 2'd3, 2'b01},  // R7 bank3 untouched
        '{32'h0000_0100, 1'b1, 2'd3, 2'b10},
        '{32'h0000_0103, 1'b1, 2'd3, 2'b11},  // R5 low bits ignored; R3 saturate high
        '{32'h0000_0100, 1'b0, 2'd3, 2'b11},  // R4 first contrary outcome
        '{32'h0000_0100, 1'b0, 2'd2, 2'b01},
        '{32'h0000_0100, 1'b0, 2'd0, 2'b10},
        '{32'h0000_0100, 1'b0, 2'd0, 2'b01},
        '{32'h0000_0100, 1'b0, 2'd0, 2'b00},  // R3 saturate low
        '{32'h0000_0100, 1'b1, 2'd0, 2'b00},
        '{32'h0000_1100, 1'b1, 2'd1, 2'b10}   // R5 high alias shares the entry
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Drive a lookup and optional update on the falling edge, sample 1 ns later.
    task automatic drive(logic [31:0] pc, logic uv, logic ut);
        @(negedge clk);
        lk_valid  = 1'b1;
        lk_pc     = pc;
        lk_offset = 32'h40;
        lk_ppc    = pc + 32'd4;
        up_valid  = uv;
        up_pc     = pc;
        up_taken  = ut;
        #1;
    endtask

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; lk_pc = '0; lk_offset = '0; lk_ppc = '0;
        up_valid = 1'b0; up_pc = '0; up_taken = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        drive(32'h0000_0100, 1'b0, 1'b0);
        check("R1 ctr", 32'(lk_ctr), 32'h1);
        check("R1 hist", 32'(lk_hist), 32'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].pc, 1'b1, VECS[i].taken);
            check("R7 hist", 32'(lk_hist), 32'(VECS[i].hist));
            check("R3 ctr", 32'(lk_ctr), 32'(VECS[i].ctr));
            check("R2 taken", 32'(lk_taken), 32'(VECS[i].ctr[1]));
            check("R8 next_pc", lk_next_pc,
                  VECS[i].ctr[1] ? VECS[i].pc + 32'h40 : VECS[i].pc + 32'd4);
            check("R9 redirect", 32'(lk_redirect), 32'(VECS[i].ctr[1]));
        end

        // R6 history after the walk is 11; a lookup alone does not shift it
        drive(32'h0000_0200, 1'b0, 1'b0);
        check("R6 hist", 32'(lk_hist), 32'h3);
        check("R5 other entry", 32'(lk_ctr), 32'h1);
        drive(32'h0000_0200, 1'b0, 1'b1);
        check("R6 hold", 32'(lk_hist), 32'h3);

        // R4 bank3 holds 10: still predicts taken after one not-taken from 11
        check("R4 dir", 32'(i_branch_dir_predictor.lk_taken), 32'h0);
        drive(32'h0000_0100, 1'b0, 1'b0);
        check("R4 still taken", 32'(lk_taken), 32'h1);

        // R10 same-cycle lookup and update of one entry
        drive(32'h0000_0100, 1'b1, 1'b1);
        check("R10 pre-update", 32'(lk_ctr), 32'h2);
        drive(32'h0000_0100, 1'b0, 1'b0);
        check("R10 post-update", 32'(lk_ctr), 32'h3);

        // R11 no update without up_valid
        drive(32'h0000_0100, 1'b0, 1'b0);
        drive(32'h0000_0100, 1'b0, 1'b0);
        check("R11 ctr", 32'(lk_ctr), 32'h3);

        // R9 no redirect when no lookup is valid
        @(negedge clk);
        lk_valid = 1'b0;
        lk_ppc   = 32'hDEAD_0000;
        #1;
        check("R9 idle", 32'(lk_redirect), 32'h0);

        // R1 reset in mid-run restores counters and history
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(32'h0000_0100, 1'b0, 1'b0);
        check("R1 ctr after reset", 32'(lk_ctr), 32'h1);
        check("R1 hist after reset", 32'(lk_hist), 32'h0);

        finish_run();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule